// File: doc/BRIEF.md
# Nibble-to-Word Transmit Assembler

This block sits at the edge of a transmit datapath. A host sends each sample as two nibbles on a 6-bit port. It qualifies them with a sync line: the nibble taken while sync is low is the upper half of a word, and the nibble taken on the next cycle with sync high is the lower half. The block runs on the nibble-rate clock, which is twice the word rate. It rebuilds each pair into a 10-bit two's-complement word for an interpolation filter and marks each new word with a one-cycle valid strobe.

When the host holds sync low for longer than one cycle, the block does not stall. On every second low cycle it presents the last completed word again, so the filter keeps receiving samples at the word rate. A host can use this to feed a steady value, such as zeros, without building new words. A separate active-high quiet enable gates the output word: while it is low, zeros go downstream.

The controller has three states:
- `ST_WAIT` (no upper nibble pending).
- `ST_HALF` (upper nibble pending, odd low count).
- `ST_REPT` (upper nibble pending, the previous low already re-issued the word).

It has five transitions:
- `low_first` takes `ST_WAIT` to `ST_HALF`.
- `low_again` takes `ST_HALF` to `ST_REPT`, and this transition re-issues the held word.
- `low_cycle` takes `ST_REPT` to `ST_HALF`.
- `high_done` takes `ST_HALF` or `ST_REPT` to `ST_WAIT`, and this transition completes a word.
- `high_stray` keeps `ST_WAIT` in `ST_WAIT`.

Top module: `tx_nibble_assembler`

## Requirements
- R1: After reset `word_valid` is low and `word_out` is zero. They stay that way until the first low-then-high sync pair has been taken.
- R2: A nibble sampled on a rising edge with `nib_sync` low becomes bits [9:5] of the next completed word.
- R3: A rising edge with `nib_sync` high, while an upper nibble is pending, completes a word. Its bits [4:0] are that edge's nibble. `word_out` shows the word and `word_valid` is high during the cycle after that edge.
- R4: A rising edge with `nib_sync` high and no upper nibble pending is ignored. `word_valid` stays low and `word_out` is unchanged.
- R5: In a run of low sync cycles, the 2nd, 4th, 6th and every later even low re-issue the held word with `word_valid` high for one cycle. The odd lows issue nothing, and every low updates the pending upper nibble.
- R6: No re-issue happens before a word has been completed since reset.
- R7: Port bit 5 has no effect. Only bits [4:0] of each nibble are used.
- R8: While `quiet_n` is low, `word_out` reads zero in the same cycle. `word_valid` is unaffected, and the held word shows again once `quiet_n` returns high.
- R9: The held word changes only on a completing edge (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_data | input | 6 | Nibble port; bits [4:0] carry data |
| nib_sync | input | 1 | Low: upper nibble; high: lower nibble |
| quiet_n | input | 1 | High lets the word pass; low forces zeros |
| word_out | output | 10 | Assembled two's-complement word |
| word_valid | output | 1 | One-cycle strobe per issued word |

## Verification
Both `word_valid` and the held word come from single registers. Each therefore reflects the rising edge at which the stimulus was sampled and is due one cycle later. `word_out` reacts to `quiet_n` combinationally, within the same cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge that samples them. It compares both outputs on the next falling edge, using the quiet value then applied, so every check lands on the first cycle its result is due.

// File: rtl/txa_pkg.sv
package txa_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HALF = 2'd1,
        ST_REPT = 2'd2
    } asm_state_t;
endpackage

// File: rtl/txa_msb_latch.sv
module txa_msb_latch #(
    parameter int PORT_W = 6,
    parameter int NIB_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] port_in,
    output logic [NIB_W-1:0]  upper_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    upper_q <= '0;
        else if (load) upper_q <= port_in[NIB_W-1:0];
    end

    AST_UPPER_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> upper_q == $past(port_in[NIB_W-1:0])); // R2
endmodule

// File: rtl/txa_seq_fsm.sv
module txa_seq_fsm
    import txa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic take_upper,
    output logic complete,
    output logic reissue
);
    asm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        take_upper = !sync_in;
        complete   = 1'b0;
        reissue    = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (!sync_in) state_d = ST_HALF;
            end
            ST_HALF: begin
                if (!sync_in) begin
                    state_d = ST_REPT;
                    reissue = 1'b1;
                end else begin
                    state_d  = ST_WAIT;
                    complete = 1'b1;
                end
            end
            ST_REPT: begin
                if (!sync_in) begin
                    state_d = ST_HALF;
                end else begin
                    state_d  = ST_WAIT;
                    complete = 1'b1;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    AST_STRAY_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && sync_in) |-> !complete && !reissue); // R4
    AST_LOW_NEVER_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_in |-> !complete); // R5
endmodule

// File: rtl/txa_word_reg.sv
module txa_word_reg #(
    parameter int PORT_W = 6,
    parameter int NIB_W  = 5,
    localparam int WORD_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              reissue,
    input  logic [NIB_W-1:0]  upper,
    input  logic [PORT_W-1:0] port_in,
    output logic [WORD_W-1:0] held_q,
    output logic              valid_q
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            valid_q <= complete || (reissue && seen_q);
            if (complete) begin
                held_q <= {upper, port_in[NIB_W-1:0]};
                seen_q <= 1'b1;
            end
        end
    end

    AST_HOLD_UNLESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(held_q)); // R9
    AST_NO_EARLY_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !complete) |=> !valid_q); // R6
    AST_LOW_HALF_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> held_q[NIB_W-1:0] == $past(port_in[NIB_W-1:0]) && valid_q); // R3
endmodule

// File: rtl/txa_quiet_gate.sv
module txa_quiet_gate #(
    parameter int WORD_W = 10
) (
    input  logic              pass_en,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);
    assign word_out = word_in & {WORD_W{pass_en}};
endmodule

// File: rtl/tx_nibble_assembler.sv
module tx_nibble_assembler #(
    parameter int PORT_W = 6,
    parameter int NIB_W  = 5,
    localparam int WORD_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] nib_data,
    input  logic              nib_sync,
    input  logic              quiet_n,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic             take_upper, complete, reissue;
    logic [NIB_W-1:0] upper;
    logic [WORD_W-1:0] held;

    txa_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_in(nib_sync),
        .take_upper(take_upper), .complete(complete), .reissue(reissue)
    );

    txa_msb_latch #(.PORT_W(PORT_W), .NIB_W(NIB_W)) u_upper (
        .clk(clk), .rst_n(rst_n), .load(take_upper),
        .port_in(nib_data), .upper_q(upper)
    );

    txa_word_reg #(.PORT_W(PORT_W), .NIB_W(NIB_W)) u_word (
        .clk(clk), .rst_n(rst_n), .complete(complete), .reissue(reissue),
        .upper(upper), .port_in(nib_data), .held_q(held), .valid_q(word_valid)
    );

    txa_quiet_gate #(.WORD_W(WORD_W)) u_gate (
        .pass_en(quiet_n), .word_in(held), .word_out(word_out)
    );

    AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (complete || reissue) |=> $stable(word_valid) || word_valid); // R5
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet_n |-> word_out == '0); // R8
endmodule

// File: tb/test_tx_nibble_assembler.sv
module test_tx_nibble_assembler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] nib_data = '0;
    logic       nib_sync = 1'b1;
    logic       quiet_n = 1'b1;
    logic [9:0] word_out;
    logic       word_valid;

    int n_vec = 0;
    int n_bad = 0;

    int       m_phase = 0;   // 0 wait, 1 odd low, 2 even low
    logic [4:0] m_upper = '0;
    logic [9:0] m_held = '0;
    logic       m_seen = 1'b0;
    logic       m_valid = 1'b0;

    always #2 clk = ~clk;

    tx_nibble_assembler i_tx_nibble_assembler (
        .clk(clk), .rst_n(rst_n), .nib_data(nib_data), .nib_sync(nib_sync),
        .quiet_n(quiet_n), .word_out(word_out), .word_valid(word_valid)
    );

    function automatic logic [9:0] exp_word(input logic [9:0] held, input logic q);
        return q ? held : 10'd0;
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (word_valid !== m_valid || word_out !== exp_word(m_held, quiet_n)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                     tag, word_valid, word_out, m_valid, exp_word(m_held, quiet_n));
        end
    endtask

    task automatic step(input logic s, input logic [5:0] d, input logic q, input string tag);
        nib_sync = s; nib_data = d; quiet_n = q;
        @(posedge clk);
        m_valid = 1'b0;
        if (!s) begin
            if (m_phase == 1) begin
                m_phase = 2;
                m_valid = m_seen;
            end else begin
                m_phase = 1;
            end
            m_upper = d[4:0];
        end else if (m_phase != 0) begin
            m_held  = {m_upper, d[4:0]};
            m_seen  = 1'b1;
            m_valid = 1'b1;
            m_phase = 0;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: valid=%0b word=%h expected run to end", word_valid, word_out);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        // R4/R1: stray high syncs before any word
        step(1'b1, 6'h15, 1'b1, "R4");
        step(1'b1, 6'h0A, 1'b1, "R4");
        // R6: long low run before any word completes: no re-issue
        step(1'b0, 6'h01, 1'b1, "R6");
        step(1'b0, 6'h02, 1'b1, "R6");
        step(1'b0, 6'h03, 1'b1, "R6");
        // R2/R3: complete first word, upper = 0x03
        step(1'b1, 6'h1F, 1'b1, "R3");
        step(1'b0, 6'h11, 1'b1, "R2");
        step(1'b1, 6'h05, 1'b1, "R2");
        // R7: bit 5 set on both nibbles
        step(1'b0, 6'h2A, 1'b1, "R7");
        step(1'b1, 6'h35, 1'b1, "R7");
        // R4: stray high after completion keeps word
        step(1'b1, 6'h00, 1'b1, "R4");
        // R5: long low run re-issues on even lows
        step(1'b0, 6'h00, 1'b1, "R5");
        step(1'b0, 6'h00, 1'b1, "R5");
        step(1'b0, 6'h00, 1'b1, "R5");
        step(1'b0, 6'h00, 1'b1, "R5");
        step(1'b0, 6'h04, 1'b1, "R5");
        step(1'b1, 6'h00, 1'b1, "R5");
        // R8: quiet gating and recovery
        step(1'b0, 6'h1E, 1'b0, "R8");
        step(1'b1, 6'h0F, 1'b0, "R8");
        step(1'b1, 6'h0F, 1'b1, "R8");
        // R9 and mix: random traffic
        for (int i = 0; i < 3000; i++) begin
            logic s, q;
            s = ($urandom % 3) != 0;
            q = ($urandom % 8) != 0;
            step(s, 6'($urandom), q, "R9");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule